// File: doc/BRIEF.md
# Codeword Error Statistics Unit

This unit sits behind a Reed-Solomon correction stage. On each beat it receives two symbols in lockstep: the symbol as it was received and the value the corrector made of it. A beat also carries start-of-packet and end-of-packet markers, which frame one codeword. Check symbols travel in the same stream as data symbols and are treated the same way. The unit passes the corrected symbol on and adds an error value to every output beat. It also adds up, across the codeword, how many symbols were changed and how many bits were flipped.

The bit count has two forms. In full mode it is one total of all differing bit positions. In split mode it is two separate totals: bits received as 1 and corrected to 0, and bits received as 0 and corrected to 1. The mode is taken on the start-of-packet beat. The statistics and a pass-through of the uncorrectable-codeword flag appear only on the output end-of-packet beat. All output is registered, with one cycle of latency, and downstream backpressure stalls both the stream and the counting.

Top module: `cw_err_stats`

## Requirements
- R1: Each output beat carries `out_data` equal to the corrected symbol and `out_err` equal to received XOR corrected. Its start and end markers match those of the input beat. The beat appears on the cycle after the input handshake.
- R2: On the output end-of-packet beat, `out_sym_cnt` equals the number of symbols in the codeword with a nonzero error value. This count includes the end-of-packet symbol itself.
- R3: In full mode (`mode_split`=0 at start of packet), `out_bits_a` on the end-of-packet beat is the total number of differing bit positions over the codeword, and `out_bits_b` is 0.
- R4: In split mode (`mode_split`=1 at start of packet), `out_bits_a` counts bits received as 1 and corrected to 0, and `out_bits_b` counts bits received as 0 and corrected to 1.
- R5: The mode is sampled only on the accepted start-of-packet beat. A change of `mode_split` later in the codeword has no effect on that codeword's counts.
- R6: All totals restart at a start-of-packet beat. This holds for back-to-back codewords with no idle cycle between them, and for a one-symbol codeword whose single beat carries both markers.
- R7: On output beats that are not end-of-packet, `out_sym_cnt`, `out_bits_a` and `out_bits_b` are 0.
- R8: `out_uncorr` equals `in_uncorr` of the end-of-packet input beat, and is 0 on every other output beat.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all outputs hold. Each input symbol is counted exactly once, on a cycle where `in_valid` and `in_ready` are both 1. After reset, `out_valid` is 0 and `in_ready` is 1.
- R10: The counters do not wrap for a codeword of MAX_N symbols with every bit flipped. With the defaults, that gives a symbol count of 255 and a bit count of 2040.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_split | input | 1 | Bit-count form, sampled at start of packet: 0 full, 1 split |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Unit can accept a beat |
| in_sop | input | 1 | First symbol of a codeword |
| in_eop | input | 1 | Last symbol of a codeword |
| in_rx | input | SYM_W | Symbol as received |
| in_fix | input | SYM_W | Symbol after correction |
| in_uncorr | input | 1 | Codeword uncorrectable; meaningful on the end-of-packet beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_sop | output | 1 | First symbol of a codeword |
| out_eop | output | 1 | Last symbol; statistics valid |
| out_data | output | SYM_W | Corrected symbol |
| out_err | output | SYM_W | Error value of this symbol |
| out_uncorr | output | 1 | Uncorrectable flag, end-of-packet beat only |
| out_sym_cnt | output | SYM_CW | Erroneous-symbol count |
| out_bits_a | output | BIT_CW | Full: all flipped bits; split: 1-to-0 flips |
| out_bits_b | output | BIT_CW | Split: 0-to-1 flips; full: 0 |

## Verification
Two things can fall in the same cycle: the end-of-packet symbol adds its own errors to the totals, and the next codeword's start-of-packet symbol clears those totals. The bench provokes this with back-to-back codewords that have errors in their last symbol, and with one-symbol codewords. It also runs these cases under random output backpressure, so that a stalled end-of-packet beat and a waiting start-of-packet beat meet. A behavioural model keeps its own per-codeword sums and compares every output beat, including the final totals and the zeros on the other beats.

// File: rtl/cwstat_pkg.sv
package cwstat_pkg;

    typedef enum logic {
        CNT_FULL  = 1'b0,
        CNT_SPLIT = 1'b1
    } cnt_mode_e;

    // bits needed to hold values 0..v
    function automatic int bits_for(input int v);
        int w;
        w = 1;
        while ((1 << w) <= v) w++;
        return w;
    endfunction

endpackage

// File: rtl/cwstat_diff.sv
module cwstat_diff
    import cwstat_pkg::*;
#(
    parameter int SYM_W = 8,
    parameter int INC_W = 4
) (
    input  logic [SYM_W-1:0] rx,
    input  logic [SYM_W-1:0] fix,
    input  cnt_mode_e        mode,
    output logic [SYM_W-1:0] err,
    output logic             has_err,
    output logic [INC_W-1:0] inc_a,
    output logic [INC_W-1:0] inc_b
);

    logic [INC_W-1:0] n10;
    logic [INC_W-1:0] n01;

    assign err     = rx ^ fix;
    assign has_err = |err;

    always_comb begin
        n10 = '0;
        n01 = '0;
        for (int i = 0; i < SYM_W; i++) begin
            n10 = n10 + INC_W'(rx[i] & ~fix[i]);
            n01 = n01 + INC_W'(~rx[i] & fix[i]);
        end
    end

    always_comb begin
        if (mode == CNT_SPLIT) begin
            inc_a = n10;
            inc_b = n01;
        end else begin
            inc_a = n10 + n01;
            inc_b = '0;
        end
    end

endmodule

// File: rtl/cwstat_accum.sv
module cwstat_accum
    import cwstat_pkg::*;
#(
    parameter int INC_W  = 4,
    parameter int SYM_CW = 8,
    parameter int BIT_CW = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              sop,
    input  cnt_mode_e         mode_in,
    input  logic              has_err,
    input  logic [INC_W-1:0]  inc_a,
    input  logic [INC_W-1:0]  inc_b,
    output cnt_mode_e         mode_eff,
    output logic [SYM_CW-1:0] sum_sym,
    output logic [BIT_CW-1:0] sum_a,
    output logic [BIT_CW-1:0] sum_b
);

    cnt_mode_e         mode_q;
    logic [SYM_CW-1:0] acc_sym;
    logic [BIT_CW-1:0] acc_a;
    logic [BIT_CW-1:0] acc_b;

    assign mode_eff = sop ? mode_in : mode_q;

    always_comb begin
        if (sop) begin
            sum_sym = SYM_CW'(has_err);
            sum_a   = BIT_CW'(inc_a);
            sum_b   = BIT_CW'(inc_b);
        end else begin
            sum_sym = acc_sym + SYM_CW'(has_err);
            sum_a   = acc_a + BIT_CW'(inc_a);
            sum_b   = acc_b + BIT_CW'(inc_b);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= CNT_FULL;
            acc_sym <= '0;
            acc_a   <= '0;
            acc_b   <= '0;
        end else if (take) begin
            mode_q  <= mode_eff;
            acc_sym <= sum_sym;
            acc_a   <= sum_a;
            acc_b   <= sum_b;
        end
    end

    // R3
    full_b_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == CNT_FULL) |-> (acc_b == '0));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !sop) |-> (sum_sym >= acc_sym && sum_a >= acc_a && sum_b >= acc_b));

endmodule

// File: rtl/cwstat_outreg.sv
module cwstat_outreg #(
    parameter int SYM_W  = 8,
    parameter int SYM_CW = 8,
    parameter int BIT_CW = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              ready,
    output logic              take,
    input  logic              sop,
    input  logic              eop,
    input  logic              uncorr,
    input  logic [SYM_W-1:0]  fix,
    input  logic [SYM_W-1:0]  err,
    input  logic [SYM_CW-1:0] sum_sym,
    input  logic [BIT_CW-1:0] sum_a,
    input  logic [BIT_CW-1:0] sum_b,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_uncorr,
    output logic [SYM_W-1:0]  out_data,
    output logic [SYM_W-1:0]  out_err,
    output logic [SYM_CW-1:0] out_sym_cnt,
    output logic [BIT_CW-1:0] out_bits_a,
    output logic [BIT_CW-1:0] out_bits_b
);

    assign ready = !out_valid || out_ready;
    assign take  = in_valid && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_sop     <= 1'b0;
            out_eop     <= 1'b0;
            out_uncorr  <= 1'b0;
            out_data    <= '0;
            out_err     <= '0;
            out_sym_cnt <= '0;
            out_bits_a  <= '0;
            out_bits_b  <= '0;
        end else if (take) begin
            out_valid   <= 1'b1;
            out_sop     <= sop;
            out_eop     <= eop;
            out_uncorr  <= eop & uncorr;
            out_data    <= fix;
            out_err     <= err;
            out_sym_cnt <= eop ? sum_sym : '0;
            out_bits_a  <= eop ? sum_a : '0;
            out_bits_b  <= eop ? sum_b : '0;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
        end
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)
            && $stable(out_eop) && $stable(out_sym_cnt) && $stable(out_bits_a)));

    // R7
    stats_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eop) |-> (out_sym_cnt == '0 && out_bits_a == '0 && out_bits_b == '0));

    // R8
    uncorr_last_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_eop) |-> !out_uncorr);

    // R2
    bits_bound_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((int'(out_bits_a) + int'(out_bits_b)) <= SYM_W * int'(out_sym_cnt)));

endmodule

// File: rtl/cw_err_stats.sv
module cw_err_stats
    import cwstat_pkg::*;
#(
    parameter int SYM_W = 8,
    parameter int MAX_N = 255,
    localparam int INC_W  = bits_for(SYM_W),
    localparam int SYM_CW = bits_for(MAX_N),
    localparam int BIT_CW = bits_for(SYM_W * MAX_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_split,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [SYM_W-1:0]  in_rx,
    input  logic [SYM_W-1:0]  in_fix,
    input  logic              in_uncorr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sop,
    output logic              out_eop,
    output logic [SYM_W-1:0]  out_data,
    output logic [SYM_W-1:0]  out_err,
    output logic              out_uncorr,
    output logic [SYM_CW-1:0] out_sym_cnt,
    output logic [BIT_CW-1:0] out_bits_a,
    output logic [BIT_CW-1:0] out_bits_b
);

    cnt_mode_e         mode_in;
    cnt_mode_e         mode_eff;
    logic [SYM_W-1:0]  err;
    logic              has_err;
    logic [INC_W-1:0]  inc_a;
    logic [INC_W-1:0]  inc_b;
    logic [SYM_CW-1:0] sum_sym;
    logic [BIT_CW-1:0] sum_a;
    logic [BIT_CW-1:0] sum_b;
    logic              take;

    assign mode_in = mode_split ? CNT_SPLIT : CNT_FULL;

    cwstat_diff #(.SYM_W(SYM_W), .INC_W(INC_W)) u_diff (
        .rx(in_rx), .fix(in_fix), .mode(mode_eff),
        .err(err), .has_err(has_err), .inc_a(inc_a), .inc_b(inc_b)
    );

    cwstat_accum #(.INC_W(INC_W), .SYM_CW(SYM_CW), .BIT_CW(BIT_CW)) u_accum (
        .clk(clk), .rst(rst), .take(take), .sop(in_sop), .mode_in(mode_in),
        .has_err(has_err), .inc_a(inc_a), .inc_b(inc_b), .mode_eff(mode_eff),
        .sum_sym(sum_sym), .sum_a(sum_a), .sum_b(sum_b)
    );

    cwstat_outreg #(.SYM_W(SYM_W), .SYM_CW(SYM_CW), .BIT_CW(BIT_CW)) u_out (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ready(in_ready), .take(take),
        .sop(in_sop), .eop(in_eop), .uncorr(in_uncorr), .fix(in_fix), .err(err),
        .sum_sym(sum_sym), .sum_a(sum_a), .sum_b(sum_b), .out_ready(out_ready),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_uncorr(out_uncorr), .out_data(out_data), .out_err(out_err),
        .out_sym_cnt(out_sym_cnt), .out_bits_a(out_bits_a), .out_bits_b(out_bits_b)
    );

endmodule

// File: tb/test_cw_err_stats.sv
module test_cw_err_stats;

    localparam int SW = 8;

    logic clk = 0;
    logic rst = 1;
    logic mode_split = 0;
    logic in_valid = 0;
    logic in_ready;
    logic in_sop = 0, in_eop = 0, in_uncorr = 0;
    logic [SW-1:0] in_rx = 0, in_fix = 0;
    logic out_valid, out_ready = 1;
    logic out_sop, out_eop, out_uncorr;
    logic [SW-1:0] out_data, out_err;
    logic [7:0]  out_sym_cnt;
    logic [10:0] out_bits_a, out_bits_b;

    always #2.5 clk = ~clk;

    cw_err_stats i_cw_err_stats (
        .clk(clk), .rst(rst), .mode_split(mode_split), .in_valid(in_valid),
        .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop), .in_rx(in_rx),
        .in_fix(in_fix), .in_uncorr(in_uncorr), .out_valid(out_valid),
        .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop),
        .out_data(out_data), .out_err(out_err), .out_uncorr(out_uncorr),
        .out_sym_cnt(out_sym_cnt), .out_bits_a(out_bits_a), .out_bits_b(out_bits_b)
    );

    typedef struct {
        logic [SW-1:0] d;
        logic [SW-1:0] e;
        bit s, l, u, split;
        int sym, a, b;
        bit [23:0] tag;
    } beat_t;

    beat_t q[$];
    int checks = 0, errors = 0;
    bit [23:0] cur_tag = "R1";
    bit bp_on = 0;
    bit done = 0;

    int m_sym, m_a, m_b;
    bit m_split;

    task automatic chk(input bit ok, input bit [23:0] tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // backpressure
    always @(posedge clk) begin
        #1;
        out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
    end

    // reference model and comparison, sampled away from the clock edge
    bit stall_prev = 0;
    logic [SW-1:0] h_d, h_e;
    logic [7:0] h_sym;
    logic [10:0] h_a;
    always @(negedge clk) begin
        if (!rst) begin
            if (stall_prev) begin
                chk(out_valid && out_data == h_d && out_err == h_e && out_sym_cnt == h_sym
                    && out_bits_a == h_a, "R9", "held output changed", int'(out_data), int'(h_d));
            end
            stall_prev = out_valid && !out_ready;
            if (stall_prev) begin
                h_d = out_data; h_e = out_err; h_sym = out_sym_cnt; h_a = out_bits_a;
                chk(!in_ready, "R9", "in_ready during stall", int'(in_ready), 0);
            end
            if (out_valid && out_ready) begin
                if (q.size() == 0) begin
                    chk(0, "R9", "unexpected output beat", 1, 0);
                end else begin
                    beat_t x;
                    x = q.pop_front();
                    chk(out_data == x.d, x.tag, "R1 data", int'(out_data), int'(x.d));
                    chk(out_err == x.e, x.tag, "R1 err", int'(out_err), int'(x.e));
                    chk(out_sop == x.s && out_eop == x.l, x.tag, "R1 markers",
                        int'({out_sop, out_eop}), int'({x.s, x.l}));
                    chk(out_uncorr == x.u, x.tag, "R8 uncorr", int'(out_uncorr), int'(x.u));
                    chk(int'(out_sym_cnt) == x.sym, x.tag, x.l ? "R2 sym count" : "R7 sym zero",
                        int'(out_sym_cnt), x.sym);
                    chk(int'(out_bits_a) == x.a, x.tag,
                        !x.l ? "R7 bits_a zero" : (x.split ? "R4 bits 1to0" : "R3 bits total"),
                        int'(out_bits_a), x.a);
                    chk(int'(out_bits_b) == x.b, x.tag,
                        !x.l ? "R7 bits_b zero" : (x.split ? "R4 bits 0to1" : "R3 bits_b zero"),
                        int'(out_bits_b), x.b);
                end
            end
            if (in_valid && in_ready) begin
                beat_t y;
                logic [SW-1:0] e;
                if (in_sop) begin
                    m_split = mode_split;
                    m_sym = 0; m_a = 0; m_b = 0;
                end
                e = in_rx ^ in_fix;
                if (e != 0) m_sym++;
                if (m_split) begin
                    m_a += $countones(in_rx & ~in_fix);
                    m_b += $countones(~in_rx & in_fix);
                end else begin
                    m_a += $countones(e);
                end
                y.d = in_fix; y.e = e; y.s = in_sop; y.l = in_eop;
                y.u = in_eop & in_uncorr; y.split = m_split; y.tag = cur_tag;
                y.sym = in_eop ? m_sym : 0;
                y.a = in_eop ? m_a : 0;
                y.b = in_eop ? m_b : 0;
                q.push_back(y);
            end
        end
    end

    task automatic drive(input bit s, input bit l, input logic [SW-1:0] rx,
                         input logic [SW-1:0] fx, input bit unc, input bit md);
        bit acc;
        in_valid = 1; in_sop = s; in_eop = l; in_rx = rx; in_fix = fx;
        in_uncorr = unc; mode_split = md;
        do begin
            @(negedge clk);
            acc = in_ready;
            @(posedge clk);
            #1;
        end while (!acc);
        in_valid = 0;
    endtask

    // pct: chance (percent) a symbol is hit; allflip inverts every bit
    task automatic send_cw(input int n, input bit m_first, input bit m_rest,
                           input int pct, input bit allflip, input bit unc_mid,
                           input bit unc_last, input bit last_err);
        for (int i = 0; i < n; i++) begin
            logic [SW-1:0] fx, msk;
            fx = SW'($urandom);
            msk = allflip ? '1 : ((($urandom % 100) < pct) ? SW'($urandom) : '0);
            if (last_err && i == n - 1 && msk == 0) msk = 8'h81;
            drive(i == 0, i == n - 1, fx ^ msk, fx, (i == n - 1) ? unc_last : unc_mid,
                  (i == 0) ? m_first : m_rest);
        end
    endtask

    task automatic gap(input int c);
        repeat (c) @(posedge clk);
        #1;
    endtask

    initial begin
        #(5 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(out_valid == 0, "R9", "reset out_valid", int'(out_valid), 0);
        chk(in_ready == 1, "R9", "reset in_ready", int'(in_ready), 1);
        @(posedge clk); #1;

        cur_tag = "R3";                       // full mode, random flips
        for (int k = 0; k < 4; k++) begin send_cw(12, 0, 0, 50, 0, 0, 0, 0); gap(2); end
        cur_tag = "R4";                       // split mode
        for (int k = 0; k < 4; k++) begin send_cw(12, 1, 1, 60, 0, 0, 0, 0); gap(1); end
        cur_tag = "R2";                       // error in the last symbol
        send_cw(6, 0, 0, 30, 0, 0, 0, 1);
        send_cw(6, 1, 1, 30, 0, 0, 0, 1);
        cur_tag = "R5";                       // mode toggles after start of packet
        send_cw(10, 0, 1, 70, 0, 0, 0, 0);
        send_cw(10, 1, 0, 70, 0, 0, 0, 0);
        gap(3);
        cur_tag = "R6";                       // back-to-back and one-symbol codewords
        for (int k = 0; k < 6; k++) send_cw(5, k[0], k[0], 80, 0, 0, 0, 1);
        for (int k = 0; k < 6; k++) send_cw(1, k[1], k[1], 100, 0, 0, 0, 1);
        cur_tag = "R8";                       // uncorrectable flag placement
        send_cw(5, 0, 0, 40, 0, 1, 1, 0);
        send_cw(5, 1, 1, 40, 0, 1, 0, 0);
        send_cw(1, 0, 0, 40, 0, 0, 1, 0);
        gap(2);
        cur_tag = "R9";                       // random downstream backpressure
        bp_on = 1;
        for (int k = 0; k < 8; k++) send_cw(1 + (k % 4) * 3, k[0], k[1], 60, 0, k[2], 1, 1);
        for (int k = 0; k < 4; k++) send_cw(1, k[0], k[0], 100, 0, 0, 1, 1);
        gap(20);
        bp_on = 0;
        gap(3);
        cur_tag = "R10";                      // longest codeword, all bits flipped
        send_cw(255, 0, 0, 0, 1, 0, 0, 0);
        send_cw(255, 1, 1, 0, 1, 0, 0, 0);
        gap(10);

        chk(q.size() == 0, "R9", "beats still pending", q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule